// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block sits between a set of interrupt request lines and one local interrupt controller. Every input line owns a routing entry that software fills in: the vector to send, a delivery-mode field, whether the line is edge or level sensitive, and a mask. When a line asks for service the block emits a message carrying the entry's vector and a bit that tells the receiver whether the source is level sensitive. Messages leave through a valid/ready handshake. When several lines want service at the same moment, the lowest-numbered line goes first.

Software reaches the block through an indirect port. It places an index on `reg_addr` and then writes `reg_wdata` with `reg_wr`, or reads `reg_rdata`. Three identity registers sit at the bottom of the index space, and each has its own write rule. The routing entries follow from index 0x10 upwards. Level-sensitive lines keep an in-service flag. The flag is set when their message is taken and cleared when an end-of-interrupt notice with a matching vector arrives on `eoi_valid`/`eoi_vector`. A line still held high is then served again without software touching the mask, and bounces of the line during a service period collapse into a single delivery.

Top module: `intr_redirect`

## Requirements
- R1: Index 0 holds the ID. A write changes only bits 27:24 of the value read back, and every other bit of index 0 always reads as 0.
- R2: Index 1 reads a fixed value, with the last entry number (line count minus 1) in bits 23:16 and 0x20 in bits 7:0. Writes to index 1 have no effect.
- R3: Index 2 reads back the ID most recently written to index 0, in bits 27:24. Writes to index 2 have no effect.
- R4: Line n's entry is read and written at index 0x10+2n as a 32-bit word with vector in bits 7:0, delivery mode in bits 10:8, in-service flag in bit 14 (read only), trigger in bit 15 (1 = level) and mask in bit 16. The word at index 0x11+2n reads as 0 and ignores writes.
- R5: An unmasked edge line sends exactly one message per rising transition, however long it stays high, with `msg_level` = 0.
- R6: A rising transition on a masked edge line is dropped and is not sent when the mask is later cleared.
- R7: A level line held high while masked sends nothing. When the mask is cleared with the line still high, exactly one message is sent.
- R8: A level line that is still high when the end-of-interrupt for its vector arrives is sent again. If it is low at that point, nothing more is sent.
- R9: A level line that falls and rises again during its service period and is low when the end-of-interrupt arrives yields only one message in total.
- R10: Level messages carry `msg_level` = 1. The entry's in-service bit reads 1 from acceptance until the matching end-of-interrupt.
- R11: When several lines request together, messages go out in increasing line order.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector` and `msg_level` stay unchanged.
- R13: After reset every entry reads 0x00010000 (masked, edge, vector 0), the ID reads 0 and no message is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Interrupt request lines, synchronous to clk |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_level | output | 1 | 1 when the source line is level sensitive |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk`. They also assume that an end-of-interrupt notice never lands in the same cycle as the acceptance of a message from the same line, and that software does not rewrite an entry's trigger mode while that line is in service. The stimulus keeps to these limits. It drives every input half a period away from the active edge. It sends end-of-interrupt notices only after the message has been taken. It changes an entry only while its line is idle or masked.

// File: rtl/irc_pkg.sv
package irc_pkg;

    localparam int VEC_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] IDX_ID  = 8'h00;
    localparam logic [ADDR_W-1:0] IDX_VER = 8'h01;
    localparam logic [ADDR_W-1:0] IDX_ARB = 8'h02;
    localparam logic [ADDR_W-1:0] IDX_TAB = 8'h10;

    localparam logic [7:0] VER_CODE = 8'h20;

    typedef struct packed {
        logic             masked;
        logic             level;
        logic [2:0]       dmode;
        logic [VEC_W-1:0] vector;
    } redir_t;

    localparam redir_t REDIR_RESET = '{masked: 1'b1, level: 1'b0, dmode: 3'd0, vector: '0};

    function automatic logic [ADDR_W-1:0] entry_index(int unsigned n);
        return IDX_TAB + ADDR_W'(2 * n);
    endfunction

    function automatic logic [DATA_W-1:0] entry_word(redir_t e, logic in_service);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[7:0]   = e.vector;
        w[10:8]  = e.dmode;
        w[14]    = in_service;
        w[15]    = e.level;
        w[16]    = e.masked;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] version_word(int unsigned lines);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[23:16] = 8'(lines - 1);
        w[7:0]   = VER_CODE;
        return w;
    endfunction

endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
    import irc_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NUM_LINES-1:0]        in_service,
    output logic [DATA_W-1:0]           rdata,
    output redir_t [NUM_LINES-1:0]      entries
);

    localparam logic [DATA_W-1:0] VERSION = version_word(NUM_LINES);

    logic [3:0]                 id_q;
    logic [3:0]                 arb_q;
    redir_t [NUM_LINES-1:0]     entry_q;
    logic                       unused_wbits;

    assign unused_wbits = ^{wdata[31:28], wdata[23:17], wdata[14:11]};

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= '0;
            arb_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                entry_q[i] <= REDIR_RESET;
            end
        end else if (wr) begin
            if (addr == IDX_ID) begin
                id_q  <= wdata[27:24];
                arb_q <= wdata[27:24];
            end
            for (int i = 0; i < NUM_LINES; i++) begin
                if (addr == entry_index(i)) begin
                    entry_q[i] <= '{masked: wdata[16], level: wdata[15],
                                    dmode: wdata[10:8], vector: wdata[7:0]};
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == IDX_ID) begin
            rdata[27:24] = id_q;
        end else if (addr == IDX_VER) begin
            rdata = VERSION;
        end else if (addr == IDX_ARB) begin
            rdata[27:24] = arb_q;
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (addr == entry_index(i)) begin
                rdata = entry_word(entry_q[i], in_service[i]);
            end
        end
    end

    assign entries = entry_q;

    p_arb_direct_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == IDX_ARB) |=> (arb_q == $past(arb_q)));

    p_id_write_field_r1: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == IDX_ID) |=> (id_q == $past(wdata[27:24]) && arb_q == id_q));

endmodule

// File: rtl/irc_source.sv
module irc_source
    import irc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq,
    input  redir_t           cfg,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             grant,
    output logic             req,
    output logic             in_service
);

    logic irq_q;
    logic edge_pend;
    logic rpend_q;
    logic rise;

    assign rise = irq && !irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q     <= 1'b0;
            edge_pend <= 1'b0;
            rpend_q   <= 1'b0;
        end else begin
            irq_q <= irq;

            if (cfg.level) begin
                edge_pend <= 1'b0;
            end else if (rise && !cfg.masked) begin
                edge_pend <= 1'b1;
            end else if (grant) begin
                edge_pend <= 1'b0;
            end

            if (!cfg.level) begin
                rpend_q <= 1'b0;
            end else if (grant) begin
                rpend_q <= 1'b1;
            end else if (eoi_valid && eoi_vector == cfg.vector) begin
                rpend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (cfg.level) begin
            req = irq && !cfg.masked && !rpend_q;
        end else begin
            req = edge_pend && !cfg.masked;
        end
    end

    assign in_service = rpend_q;

    p_masked_edge_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_pend) |-> $past(!cfg.masked && irq));

    p_inservice_from_accept_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rpend_q) |-> $past(grant));

    p_inservice_cleared_by_eoi_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(rpend_q) && $past(cfg.level)) |-> $past(eoi_valid && eoi_vector == cfg.vector));

endmodule

// File: rtl/irc_dispatch.sv
module irc_dispatch
    import irc_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_LINES-1:0]    req,
    input  redir_t [NUM_LINES-1:0]  cfgs,
    input  logic                    msg_ready,
    output logic                    msg_valid,
    output logic [VEC_W-1:0]        msg_vector,
    output logic                    msg_level,
    output logic [NUM_LINES-1:0]    grant
);

    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic              out_valid;
    logic [LINE_W-1:0] out_line;
    logic [VEC_W-1:0]  out_vec;
    logic              out_lvl;
    logic [LINE_W-1:0] pick;
    logic              any_req;

    always_comb begin
        pick    = '0;
        any_req = |req;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick = LINE_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_line  <= '0;
            out_vec   <= '0;
            out_lvl   <= 1'b0;
        end else if (out_valid) begin
            if (msg_ready) begin
                out_valid <= 1'b0;
            end
        end else if (any_req) begin
            out_valid <= 1'b1;
            out_line  <= pick;
            out_vec   <= cfgs[pick].vector;
            out_lvl   <= cfgs[pick].level;
        end
    end

    always_comb begin
        grant = '0;
        if (out_valid && msg_ready) begin
            grant[out_line] = 1'b1;
        end
    end

    assign msg_valid  = out_valid;
    assign msg_vector = out_vec;
    assign msg_level  = out_lvl;

    p_hold_until_ready_r12: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_level)));

    p_single_grant_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_idle_picks_up_r11: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && any_req) |=> msg_valid);

endmodule

// File: rtl/intr_redirect.sv
module intr_redirect
    import irc_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [7:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_vector,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic                 msg_level
);

    redir_t [NUM_LINES-1:0] entries;
    logic [NUM_LINES-1:0]   in_service;
    logic [NUM_LINES-1:0]   req;
    logic [NUM_LINES-1:0]   grant;

    irc_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (reg_addr),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .in_service (in_service),
        .rdata      (reg_rdata),
        .entries    (entries)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irc_source u_src (
            .clk        (clk),
            .rst        (rst),
            .irq        (irq_in[g]),
            .cfg        (entries[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .grant      (grant[g]),
            .req        (req[g]),
            .in_service (in_service[g])
        );
    end

    irc_dispatch #(.NUM_LINES(NUM_LINES)) u_disp (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .cfgs       (entries),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector),
        .msg_level  (msg_level),
        .grant      (grant)
    );

endmodule

// File: tb/intr_redirect_test.sv
module intr_redirect_test;

    localparam int N = 4;
    localparam logic [31:0] VERSION = {8'h00, 8'(N - 1), 8'h00, 8'h20};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic [7:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         eoi_valid = 1'b0;
    logic [7:0]   eoi_vector = '0;
    logic         msg_valid;
    logic         msg_ready = 1'b0;
    logic [7:0]   msg_vector;
    logic         msg_level;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    intr_redirect #(.NUM_LINES(N)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_level(msg_level)
    );

    // {index, write data, expected read-back}
    localparam int NV = 8;
    localparam logic [71:0] REG_VEC [NV] = '{
        {8'h00, 32'hFFFF_FFFF, 32'h0F00_0000},  // R1
        {8'h01, 32'hFFFF_FFFF, VERSION},        // R2
        {8'h02, 32'h0000_0000, 32'h0F00_0000},  // R3
        {8'h00, 32'h0500_0000, 32'h0500_0000},  // R1
        {8'h02, 32'hFFFF_FFFF, 32'h0500_0000},  // R3
        {8'h10, 32'h0001_8176, 32'h0001_8176},  // R4
        {8'h10, 32'hFFFF_FFFF, 32'h0001_87FF},  // R4 bit 14 read only
        {8'h11, 32'hFFFF_FFFF, 32'h0000_0000}   // R4 high word
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid  = 1'b1;
        eoi_vector = v;
        @(negedge clk);
        eoi_valid  = 1'b0;
    endtask

    task automatic expect_msg(input logic [7:0] v, input logic lvl, input string tag);
        int n = 0;
        while (!msg_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(msg_valid === 1'b1, {tag, " valid"}, 32'(msg_valid), 32'd1);
        check(msg_vector === v && msg_level === lvl, {tag, " content"},
              {23'd0, msg_level, msg_vector}, {23'd0, lvl, v});
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_none(input int cycles, input string tag);
        bit seen = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, tag, 32'(seen), 32'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        reg_read(8'h10, rd);
        check(rd === 32'h0001_0000, "R13 entry reset", rd, 32'h0001_0000);
        reg_read(8'h00, rd);
        check(rd === 32'h0, "R13 id reset", rd, 32'h0);
        check(msg_valid === 1'b0, "R13 no message", 32'(msg_valid), 32'd0);

        // register table walk
        for (int i = 0; i < NV; i++) begin
            logic [71:0] e;
            e = REG_VEC[i];
            reg_write(e[71:64], e[63:32]);
            reg_read(e[71:64], rd);
            check(rd === e[31:0], $sformatf("R1-reg-table entry %0d (R2 R3 R4)", i), rd, e[31:0]);
        end
        check(msg_valid === 1'b0, "R4 table writes masked, no message", 32'(msg_valid), 32'd0);

        // R5 edge, one message per rise
        reg_write(8'h10, 32'h0000_0076);
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk); irq_in[0] = 1'b0;
        expect_msg(8'h76, 1'b0, "R5 edge pulse");
        expect_none(6, "R5 single message");
        @(negedge clk); irq_in[0] = 1'b1;
        expect_msg(8'h76, 1'b0, "R5 edge held");
        expect_none(8, "R5 held high sends one");
        irq_in[0] = 1'b0;

        // R6 masked edge dropped
        reg_write(8'h10, 32'h0001_0076);
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk); irq_in[0] = 1'b0;
        expect_none(5, "R6 masked edge");
        reg_write(8'h10, 32'h0000_0076);
        expect_none(6, "R6 not sent after unmask");

        // R7 / R10 level with mask
        reg_write(8'h12, 32'h0001_8077);
        @(negedge clk); irq_in[1] = 1'b1;
        expect_none(6, "R7 masked level");
        reg_write(8'h12, 32'h0000_8077);
        expect_msg(8'h77, 1'b1, "R7 R10 unmask level");
        reg_read(8'h12, rd);
        check(rd === 32'h0000_C077, "R10 in-service bit set", rd, 32'h0000_C077);
        expect_none(6, "R7 one message while in service");

        // R8 re-delivery
        send_eoi(8'h77);
        expect_msg(8'h77, 1'b1, "R8 redeliver after eoi");
        @(negedge clk); irq_in[1] = 1'b0;
        send_eoi(8'h77);
        expect_none(6, "R8 low at eoi");
        reg_read(8'h12, rd);
        check(rd === 32'h0000_8077, "R10 in-service bit cleared", rd, 32'h0000_8077);

        // R9 coalescing
        @(negedge clk); irq_in[1] = 1'b1;
        expect_msg(8'h77, 1'b1, "R9 first delivery");
        @(negedge clk); irq_in[1] = 1'b0;
        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk); irq_in[1] = 1'b0;
        expect_none(3, "R9 bounce while in service");
        send_eoi(8'h77);
        expect_none(6, "R9 coalesced");

        // R11 / R12 priority and hold
        reg_write(8'h16, 32'h0000_0041);
        reg_write(8'h14, 32'h0000_0040);
        @(negedge clk); irq_in[3:2] = 2'b11;
        @(negedge clk); irq_in[3:2] = 2'b00;
        repeat (5) @(negedge clk);
        check(msg_valid === 1'b1 && msg_vector === 8'h40, "R12 held while not ready",
              {23'd0, msg_valid, msg_vector}, {23'd0, 1'b1, 8'h40});
        expect_msg(8'h40, 1'b0, "R11 lowest first");
        expect_msg(8'h41, 1'b0, "R11 next line");
        expect_none(5, "R11 no extra");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule